// File: doc/BRIEF.md
# Register Rename Table with Result-Holding Reorder Buffer

This block renames registers for an out-of-order core whose committed state lives in a small architectural register file. Speculative results never go to a separate physical register pool. They wait in a circular reorder buffer until they retire in program order. Each architectural register has one mapping entry. The entry holds a location flag, which says whether the newest value is in the register file or in the buffer, and the buffer slot that will produce that value. Each buffer slot holds the destination register number, the result value, and a flag that is set once the result has been written back.

The rename stream carries one instruction per handshake: two source register numbers and one destination register number. The accepting cycle does four things. It returns the destination's newly allocated slot id. For each source, it returns either a ready value or the slot id to wait on. It then points the destination's mapping at that slot. Writebacks come in by slot id and are always accepted. The commit stream offers the oldest slot once that slot's result is present. On acceptance the value is copied into the register file, and the mapping is released if it still names that slot. A flush input empties the buffer and sends every mapping back to the register file. No free list is involved.

Top module: `arf_rename_unit`

## Requirements
- R1: After reset, every register reads as ready with value 0 from the register file, `ren_ready` is 1, `ren_rob_id` is 0 and `cmt_valid` is 0.
- R2: A source whose mapping points at the register file returns `srcN_in_rob`=0, `srcN_ready`=1 and the committed value.
- R3: An accepted rename (`ren_valid` and `ren_ready` both 1 at a clock edge) takes the slot shown on `ren_rob_id`. Later lookups of its destination return `srcN_in_rob`=1, `srcN_tag` equal to that slot, and `srcN_ready`=0 until writeback.
- R4: A writeback (`wb_valid`=1) stores `wb_value` in slot `wb_rob_id` and marks it ready. From the next cycle, a source mapped to that slot returns `srcN_ready`=1 and the stored value.
- R5: Lookups reflect the state at the start of the cycle. A source equal to the same instruction's destination sees the older mapping, and a writeback in the same cycle is not yet visible.
- R6: `cmt_valid` is 1 only when the oldest slot holds a written result, even if younger slots are ready. It presents that slot's id, destination and value. The handshake (`cmt_valid` and `cmt_ready`) writes the value into the register file and retires the slot.
- R7: A commit returns the destination's mapping to the register file only if the mapping still names the retiring slot. A rename of the same register in the same cycle, or earlier, keeps the younger mapping.
- R8: With all `ROB_DEPTH` slots occupied, `ren_ready` is 0. A rename offered while `ren_ready` is 0 changes no mapping and takes no slot.
- R9: After a cycle with `flush`=1, every source reads from the register file, committed values are kept, no commit is offered, and the next rename receives slot 0.
- R10: During a cycle with `flush`=1, `ren_ready` and `cmt_valid` are 0 and writebacks are ignored.
- R11: Slot ids are given out in order and wrap from `ROB_DEPTH`-1 back to 0 once older slots have retired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard all speculative state |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename can be accepted (buffer not full, no flush) |
| ren_src0 | input | AREG_W (4) | First source register |
| ren_src1 | input | AREG_W (4) | Second source register |
| ren_dst | input | AREG_W (4) | Destination register |
| ren_rob_id | output | ROB_IDW (3) | Slot given to this rename |
| src0_in_rob | output | 1 | First source mapped to a buffer slot |
| src0_tag | output | ROB_IDW (3) | Slot the first source waits on |
| src0_ready | output | 1 | First source value available |
| src0_value | output | DATA_W (32) | First source value (0 when not ready) |
| src1_in_rob | output | 1 | Second source mapped to a buffer slot |
| src1_tag | output | ROB_IDW (3) | Slot the second source waits on |
| src1_ready | output | 1 | Second source value available |
| src1_value | output | DATA_W (32) | Second source value (0 when not ready) |
| wb_valid | input | 1 | Result writeback present (always accepted) |
| wb_rob_id | input | ROB_IDW (3) | Slot receiving the result |
| wb_value | input | DATA_W (32) | Result value |
| cmt_valid | output | 1 | Oldest slot is ready to retire |
| cmt_ready | input | 1 | Consumer accepts the retirement |
| cmt_rob_id | output | ROB_IDW (3) | Retiring slot |
| cmt_dst | output | AREG_W (4) | Register written by the retirement |
| cmt_value | output | DATA_W (32) | Value written by the retirement |

Rename and commit follow valid/ready rules. A transfer happens on a clock edge where both signals are 1. `ren_ready` does not depend on `ren_valid`, and `cmt_valid` does not depend on `cmt_ready`. A rename held while `ren_ready` is 0 has no effect.

## Verification
A corrupted mapping entry shows up in the same cycle at the source lookup outputs of any rename that reads that register: a wrong location flag, tag or value. A wrong buffer pointer or ready flag shows up as a mismatched `ren_rob_id`, or as `cmt_valid` rising too early or staying low. The mistake also reaches the register file, and appears one cycle after the faulty commit when that register is read from the register file. Flush faults appear on the first cycle after the flush, as a stale buffer mapping or a slot id other than 0.

// File: rtl/arf_rename_pkg.sv
package arf_rename_pkg;
  typedef enum logic {
    LOC_ARF = 1'b0,
    LOC_ROB = 1'b1
  } loc_e;
endpackage

// File: rtl/arf_regfile.sv
module arf_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata0 = mem_q[raddr0];
  assign rdata1 = mem_q[raddr1];

  AST_ARF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(waddr)] == $past(wdata)); // R6
endmodule

// File: rtl/arf_map_table.sv
module arf_map_table #(
  parameter int NREG = 16,
  parameter int IDW  = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           set_en,
  input  logic [AW-1:0]  set_reg,
  input  logic [IDW-1:0] set_id,
  input  logic           clr_en,
  input  logic [AW-1:0]  clr_reg,
  input  logic [IDW-1:0] clr_id,
  input  logic [AW-1:0]  rd0_reg,
  input  logic [AW-1:0]  rd1_reg,
  output logic           rd0_loc,
  output logic [IDW-1:0] rd0_id,
  output logic           rd1_loc,
  output logic [IDW-1:0] rd1_id
);
  logic [NREG-1:0] loc_q;
  logic [IDW-1:0]  id_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_reg == AW'(g));
    assign hit_clr = clr_en && (clr_reg == AW'(g)) && loc_q[g] && (id_q[g] == clr_id);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        loc_q[g] <= 1'b0;
        id_q[g]  <= '0;
      end else if (flush) begin
        loc_q[g] <= 1'b0;
      end else if (hit_set) begin
        loc_q[g] <= 1'b1;
        id_q[g]  <= set_id;
      end else if (hit_clr) begin
        loc_q[g] <= 1'b0;
      end
    end
  end

  assign rd0_loc = loc_q[rd0_reg];
  assign rd0_id  = id_q[rd0_reg];
  assign rd1_loc = loc_q[rd1_reg];
  assign rd1_id  = id_q[rd1_reg];

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> loc_q == '0); // R9
  AST_RENAME_MAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !flush) |=> loc_q[$past(set_reg)] && id_q[$past(set_reg)] == $past(set_id)); // R3
endmodule

// File: rtl/arf_rob.sv
module arf_rob #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int RW    = 4,
  localparam int IDW  = $clog2(DEPTH),
  localparam int PW   = IDW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           alloc_en,
  input  logic [RW-1:0]  alloc_dst,
  output logic [IDW-1:0] tail_id,
  output logic           full,
  input  logic           wb_en,
  input  logic [IDW-1:0] wb_id,
  input  logic [DW-1:0]  wb_data,
  input  logic           pop_en,
  output logic           head_valid,
  output logic [IDW-1:0] head_id,
  output logic [RW-1:0]  head_dst,
  output logic [DW-1:0]  head_data,
  input  logic [IDW-1:0] rd0_id,
  output logic           rd0_ready,
  output logic [DW-1:0]  rd0_data,
  input  logic [IDW-1:0] rd1_id,
  output logic           rd1_ready,
  output logic [DW-1:0]  rd1_data
);
  logic [PW-1:0]    head_q, tail_q;
  logic [DEPTH-1:0] rdy_q;
  logic [DW-1:0]    data_q [DEPTH];
  logic [RW-1:0]    dst_q  [DEPTH];
  logic             empty;

  assign head_id = head_q[IDW-1:0];
  assign tail_id = tail_q[IDW-1:0];
  assign empty   = (head_q == tail_q);
  assign full    = (head_q[IDW-1:0] == tail_q[IDW-1:0]) && (head_q[IDW] != tail_q[IDW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc_en) tail_q <= tail_q + PW'(1);
      if (pop_en)   head_q <= head_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        data_q[i] <= '0;
        dst_q[i]  <= '0;
      end
    end else if (!flush) begin
      if (wb_en) begin
        rdy_q[wb_id]  <= 1'b1;
        data_q[wb_id] <= wb_data;
      end
      if (alloc_en) begin
        rdy_q[tail_id] <= 1'b0;
        dst_q[tail_id] <= alloc_dst;
      end
    end
  end

  assign head_valid = !empty && rdy_q[head_id];
  assign head_dst   = dst_q[head_id];
  assign head_data  = data_q[head_id];
  assign rd0_ready  = rdy_q[rd0_id];
  assign rd0_data   = data_q[rd0_id];
  assign rd1_ready  = rdy_q[rd1_id];
  assign rd1_data   = data_q[rd1_id];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full); // R8
  AST_HEAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (!empty && rdy_q[head_id])); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && tail_q == '0)); // R9
endmodule

// File: rtl/arf_src_select.sv
module arf_src_select
  import arf_rename_pkg::*;
#(
  parameter int DW  = 32,
  parameter int IDW = 3
) (
  input  logic           map_loc,
  input  logic [IDW-1:0] map_id,
  input  logic [DW-1:0]  arf_value,
  input  logic           rob_ready,
  input  logic [DW-1:0]  rob_value,
  output logic           in_rob,
  output logic [IDW-1:0] tag,
  output logic           ready,
  output logic [DW-1:0]  value
);
  loc_e loc;
  assign loc = loc_e'(map_loc);

  always_comb begin
    in_rob = (loc == LOC_ROB);
    tag    = map_id;
    ready  = 1'b1;
    value  = arf_value;
    if (loc == LOC_ROB) begin
      ready = rob_ready;
      value = rob_ready ? rob_value : '0;
    end
  end
endmodule

// File: rtl/arf_rename_unit.sv
module arf_rename_unit #(
  parameter int NUM_AREG  = 16,
  parameter int DATA_W    = 32,
  parameter int ROB_DEPTH = 8,
  localparam int AREG_W   = $clog2(NUM_AREG),
  localparam int ROB_IDW  = $clog2(ROB_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               ren_valid,
  output logic               ren_ready,
  input  logic [AREG_W-1:0]  ren_src0,
  input  logic [AREG_W-1:0]  ren_src1,
  input  logic [AREG_W-1:0]  ren_dst,
  output logic [ROB_IDW-1:0] ren_rob_id,
  output logic               src0_in_rob,
  output logic [ROB_IDW-1:0] src0_tag,
  output logic               src0_ready,
  output logic [DATA_W-1:0]  src0_value,
  output logic               src1_in_rob,
  output logic [ROB_IDW-1:0] src1_tag,
  output logic               src1_ready,
  output logic [DATA_W-1:0]  src1_value,
  input  logic               wb_valid,
  input  logic [ROB_IDW-1:0] wb_rob_id,
  input  logic [DATA_W-1:0]  wb_value,
  output logic               cmt_valid,
  input  logic               cmt_ready,
  output logic [ROB_IDW-1:0] cmt_rob_id,
  output logic [AREG_W-1:0]  cmt_dst,
  output logic [DATA_W-1:0]  cmt_value
);
  localparam int NSRC = 2;

  logic               rob_full, head_valid, ren_fire, cmt_fire;
  logic [ROB_IDW-1:0] tail_id, head_id;
  logic [AREG_W-1:0]  head_dst;
  logic [DATA_W-1:0]  head_data;

  logic [AREG_W-1:0]  s_reg   [NSRC];
  logic               s_loc   [NSRC];
  logic [ROB_IDW-1:0] s_id    [NSRC];
  logic [DATA_W-1:0]  s_arf   [NSRC];
  logic               s_rrdy  [NSRC];
  logic [DATA_W-1:0]  s_rval  [NSRC];
  logic               o_inrob [NSRC];
  logic [ROB_IDW-1:0] o_tag   [NSRC];
  logic               o_rdy   [NSRC];
  logic [DATA_W-1:0]  o_val   [NSRC];

  assign ren_ready  = !rob_full && !flush;
  assign ren_fire   = ren_valid && ren_ready;
  assign cmt_valid  = head_valid && !flush;
  assign cmt_fire   = cmt_valid && cmt_ready;
  assign ren_rob_id = tail_id;
  assign cmt_rob_id = head_id;
  assign cmt_dst    = head_dst;
  assign cmt_value  = head_data;

  assign s_reg[0] = ren_src0;
  assign s_reg[1] = ren_src1;

  arf_regfile #(.NREG(NUM_AREG), .DW(DATA_W)) u_arf (
    .clk(clk), .rst_n(rst_n),
    .we(cmt_fire), .waddr(head_dst), .wdata(head_data),
    .raddr0(s_reg[0]), .raddr1(s_reg[1]),
    .rdata0(s_arf[0]), .rdata1(s_arf[1])
  );

  arf_map_table #(.NREG(NUM_AREG), .IDW(ROB_IDW)) u_map (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .set_en(ren_fire), .set_reg(ren_dst), .set_id(tail_id),
    .clr_en(cmt_fire), .clr_reg(head_dst), .clr_id(head_id),
    .rd0_reg(s_reg[0]), .rd1_reg(s_reg[1]),
    .rd0_loc(s_loc[0]), .rd0_id(s_id[0]),
    .rd1_loc(s_loc[1]), .rd1_id(s_id[1])
  );

  arf_rob #(.DEPTH(ROB_DEPTH), .DW(DATA_W), .RW(AREG_W)) u_rob (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_en(ren_fire), .alloc_dst(ren_dst),
    .tail_id(tail_id), .full(rob_full),
    .wb_en(wb_valid && !flush), .wb_id(wb_rob_id), .wb_data(wb_value),
    .pop_en(cmt_fire), .head_valid(head_valid),
    .head_id(head_id), .head_dst(head_dst), .head_data(head_data),
    .rd0_id(s_id[0]), .rd0_ready(s_rrdy[0]), .rd0_data(s_rval[0]),
    .rd1_id(s_id[1]), .rd1_ready(s_rrdy[1]), .rd1_data(s_rval[1])
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    arf_src_select #(.DW(DATA_W), .IDW(ROB_IDW)) u_sel (
      .map_loc(s_loc[g]), .map_id(s_id[g]), .arf_value(s_arf[g]),
      .rob_ready(s_rrdy[g]), .rob_value(s_rval[g]),
      .in_rob(o_inrob[g]), .tag(o_tag[g]), .ready(o_rdy[g]), .value(o_val[g])
    );
  end

  assign src0_in_rob = o_inrob[0];
  assign src0_tag    = o_tag[0];
  assign src0_ready  = o_rdy[0];
  assign src0_value  = o_val[0];
  assign src1_in_rob = o_inrob[1];
  assign src1_tag    = o_tag[1];
  assign src1_ready  = o_rdy[1];
  assign src1_value  = o_val[1];

  AST_STALL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_ready && !flush) |=> $stable(ren_rob_id)); // R8
endmodule

// File: tb/test_arf_rename_unit.sv
`timescale 1ns/1ps
module test_arf_rename_unit;
  logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic        ren_valid = 1'b0, ren_ready;
  logic [3:0]  ren_src0 = '0, ren_src1 = '0, ren_dst = '0;
  logic [2:0]  ren_rob_id;
  logic        src0_in_rob, src0_ready, src1_in_rob, src1_ready;
  logic [2:0]  src0_tag, src1_tag;
  logic [31:0] src0_value, src1_value;
  logic        wb_valid = 1'b0;
  logic [2:0]  wb_rob_id = '0;
  logic [31:0] wb_value = '0;
  logic        cmt_valid, cmt_ready = 1'b0;
  logic [2:0]  cmt_rob_id;
  logic [3:0]  cmt_dst;
  logic [31:0] cmt_value;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  arf_rename_unit i_arf_rename_unit (
    .clk, .rst_n, .flush, .ren_valid, .ren_ready, .ren_src0, .ren_src1, .ren_dst,
    .ren_rob_id, .src0_in_rob, .src0_tag, .src0_ready, .src0_value,
    .src1_in_rob, .src1_tag, .src1_ready, .src1_value,
    .wb_valid, .wb_rob_id, .wb_value,
    .cmt_valid, .cmt_ready, .cmt_rob_id, .cmt_dst, .cmt_value
  );

  typedef struct packed {
    logic        ren_v;
    logic [3:0]  s0;
    logic [3:0]  dst;
    logic        wb_v;
    logic [2:0]  wb_id;
    logic [31:0] wb_val;
    logic        c_rdy;
    logic [2:0]  e_rid;
    logic        e_inrob;
    logic [2:0]  e_tag;
    logic        e_rdy;
    logic [31:0] e_val;
    logic        e_cv;
    logic [2:0]  e_cid;
    logic [3:0]  e_cdst;
    logic [31:0] e_cval;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    // R2: source r1 read from the register file; dst r1 renamed to slot 0
    '{1'b1, 4'd1, 4'd1, 1'b0, 3'd0, 32'h0,  1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 32'h0,  1'b0, 3'd0, 4'd0, 32'h0,  8'd2},
    // R3: r1 now waits on slot 0; r2 renamed to slot 1
    '{1'b1, 4'd1, 4'd2, 1'b0, 3'd0, 32'h0,  1'b0, 3'd1, 1'b1, 3'd0, 1'b0, 32'h0,  1'b0, 3'd0, 4'd0, 32'h0,  8'd3},
    // R5: writeback to slot 1 not visible in its own cycle
    '{1'b0, 4'd2, 4'd0, 1'b1, 3'd1, 32'h22, 1'b0, 3'd2, 1'b1, 3'd1, 1'b0, 32'h0,  1'b0, 3'd0, 4'd0, 32'h0,  8'd5},
    // R4: slot 1 value now returned; R6 head slot 0 still pending so no commit
    '{1'b0, 4'd2, 4'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd2, 1'b1, 3'd1, 1'b1, 32'h22, 1'b0, 3'd0, 4'd0, 32'h0,  8'd4},
    // R6: writeback slot 0; commit not yet offered
    '{1'b0, 4'd1, 4'd0, 1'b1, 3'd0, 32'h11, 1'b1, 3'd2, 1'b1, 3'd0, 1'b0, 32'h0,  1'b0, 3'd0, 4'd0, 32'h0,  8'd6},
    // R6: slot 0 offered and accepted
    '{1'b0, 4'd1, 4'd0, 1'b0, 3'd0, 32'h0,  1'b1, 3'd2, 1'b1, 3'd0, 1'b1, 32'h11, 1'b1, 3'd0, 4'd1, 32'h11, 8'd6},
    // R7: r1 mapping released; value read from the register file
    '{1'b0, 4'd1, 4'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd2, 1'b0, 3'd0, 1'b1, 32'h11, 1'b1, 3'd1, 4'd2, 32'h22, 8'd7},
    // R7: rename r2 to slot 2 while slot 1 (r2) commits
    '{1'b1, 4'd2, 4'd2, 1'b0, 3'd0, 32'h0,  1'b1, 3'd2, 1'b1, 3'd1, 1'b1, 32'h22, 1'b1, 3'd1, 4'd2, 32'h22, 8'd7},
    // R7: younger mapping of r2 kept
    '{1'b0, 4'd2, 4'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd3, 1'b1, 3'd2, 1'b0, 32'h0,  1'b0, 3'd0, 4'd0, 32'h0,  8'd7}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = 1'b0; wb_valid = 1'b0; cmt_ready = 1'b0; flush = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    string r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    ren_src0 = 4'd15; ren_src1 = 4'd2;
    #1;
    chk("R1", "ren_ready", 32'(ren_ready), 32'd1);
    chk("R1", "ren_rob_id", 32'(ren_rob_id), 32'd0);
    chk("R1", "cmt_valid", 32'(cmt_valid), 32'd0);
    chk("R1", "src0_in_rob", 32'(src0_in_rob), 32'd0);
    chk("R1", "src0_ready", 32'(src0_ready), 32'd1);
    chk("R1", "src0_value", src0_value, 32'd0);
    chk("R1", "src1_ready", 32'(src1_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ren_valid = VEC[i].ren_v; ren_src0 = VEC[i].s0; ren_src1 = 4'd0; ren_dst = VEC[i].dst;
      wb_valid = VEC[i].wb_v; wb_rob_id = VEC[i].wb_id; wb_value = VEC[i].wb_val;
      cmt_ready = VEC[i].c_rdy;
      #1;
      r = $sformatf("R%0d", VEC[i].req);
      chk(r, "ren_ready", 32'(ren_ready), 32'd1);
      chk(r, "ren_rob_id", 32'(ren_rob_id), 32'(VEC[i].e_rid));
      chk(r, "src0_in_rob", 32'(src0_in_rob), 32'(VEC[i].e_inrob));
      if (VEC[i].e_inrob) chk(r, "src0_tag", 32'(src0_tag), 32'(VEC[i].e_tag));
      chk(r, "src0_ready", 32'(src0_ready), 32'(VEC[i].e_rdy));
      if (VEC[i].e_rdy) chk(r, "src0_value", src0_value, VEC[i].e_val);
      chk(r, "cmt_valid", 32'(cmt_valid), 32'(VEC[i].e_cv));
      if (VEC[i].e_cv) begin
        chk(r, "cmt_rob_id", 32'(cmt_rob_id), 32'(VEC[i].e_cid));
        chk(r, "cmt_dst", 32'(cmt_dst), 32'(VEC[i].e_cdst));
        chk(r, "cmt_value", cmt_value, VEC[i].e_cval);
      end
    end

    // R10: flush cycle blocks rename and commit, ignores writeback
    @(negedge clk);
    idle();
    flush = 1'b1; ren_valid = 1'b1; ren_dst = 4'd5; cmt_ready = 1'b1;
    wb_valid = 1'b1; wb_rob_id = 3'd2; wb_value = 32'h99;
    #1;
    chk("R10", "ren_ready", 32'(ren_ready), 32'd0);
    chk("R10", "cmt_valid", 32'(cmt_valid), 32'd0);

    // R9: after flush
    @(negedge clk);
    idle();
    ren_src0 = 4'd2; ren_src1 = 4'd1;
    #1;
    chk("R9", "src0_in_rob", 32'(src0_in_rob), 32'd0);
    chk("R9", "src0_value", src0_value, 32'h22);
    chk("R2", "src1_value", src1_value, 32'h11);
    chk("R9", "ren_rob_id", 32'(ren_rob_id), 32'd0);
    chk("R9", "cmt_valid", 32'(cmt_valid), 32'd0);
    ren_src0 = 4'd5;
    #0.5;
    chk("R10", "src0_in_rob r5", 32'(src0_in_rob), 32'd0);

    // R11: fill all slots in order
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      idle();
      ren_valid = 1'b1; ren_dst = 4'(3 + i); ren_src0 = 4'd0;
      #1;
      chk("R11", "ren_ready", 32'(ren_ready), 32'd1);
      chk("R11", "ren_rob_id", 32'(ren_rob_id), 32'(i));
    end

    // R8: full buffer refuses rename
    @(negedge clk);
    idle();
    ren_valid = 1'b1; ren_dst = 4'd12; ren_src0 = 4'd12;
    #1;
    chk("R8", "ren_ready", 32'(ren_ready), 32'd0);
    @(negedge clk);
    idle();
    ren_src0 = 4'd12;
    #1;
    chk("R8", "src0_in_rob r12", 32'(src0_in_rob), 32'd0);
    chk("R8", "ren_ready", 32'(ren_ready), 32'd0);

    // R6: retire slot 0 (r3)
    @(negedge clk);
    idle();
    wb_valid = 1'b1; wb_rob_id = 3'd0; wb_value = 32'h55;
    @(negedge clk);
    idle();
    cmt_ready = 1'b1;
    #1;
    chk("R6", "cmt_valid", 32'(cmt_valid), 32'd1);
    chk("R6", "cmt_dst", 32'(cmt_dst), 32'd3);
    chk("R6", "cmt_value", cmt_value, 32'h55);

    // R11: freed slot 0 reused after wrap
    @(negedge clk);
    idle();
    ren_valid = 1'b1; ren_dst = 4'd12;
    #1;
    chk("R11", "ren_ready", 32'(ren_ready), 32'd1);
    chk("R11", "ren_rob_id wrap", 32'(ren_rob_id), 32'd0);
    @(negedge clk);
    idle();
    ren_src0 = 4'd12; ren_src1 = 4'd3;
    #1;
    chk("R11", "src0_in_rob", 32'(src0_in_rob), 32'd1);
    chk("R11", "src0_tag", 32'(src0_tag), 32'd0);
    chk("R11", "src0_ready", 32'(src0_ready), 32'd0);
    chk("R7", "src1_in_rob r3", 32'(src1_in_rob), 32'd0);
    chk("R7", "src1_value r3", src1_value, 32'h55);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule